// File: doc/BRIEF.md
# Page Write Staging Buffer with Timed Commit

This block sits between a two-wire serial slave front end and a byte-wide storage array. During a write transaction the front end first hands it a word address and then a stream of data bytes. The bytes are held in a page buffer of `2**PAGE_AW` entries. The low address bits pick the entry, and only those bits advance after each byte, so a long burst wraps inside its page and later bytes replace earlier ones. A per-entry valid mask records which entries the current transaction has touched.

A STOP that follows at least one data byte starts a self-timed programming cycle of `WR_CYCLES` clock cycles, during which `busy_o` is high. In the first `2**PAGE_AW` cycles of that window the block walks the buffer in ascending entry order and issues one array write for each valid entry, into the page held in the upper pointer bits. While busy, every strobe is ignored, so the front end can withhold its acknowledge. A repeated START (abort) or a STOP with no data commits nothing. A high write-protect input leaves buffering and pointer movement intact but suppresses every array write and the busy window. The address pointer is the shared pointer for reads: after a transaction it holds the address just past the last byte received, with the wrap inside the page applied.

States: `ST_IDLE` (no transaction), `ST_ADDR` (word address held, no data yet), `ST_DATA` (at least one byte buffered), `ST_PROG` (timed commit). Transitions: IDLE→ADDR on address strobe; ADDR→ADDR on a new address strobe; ADDR→DATA on a byte; ADDR→IDLE on STOP or abort; DATA→ADDR on a new address strobe (the buffer is discarded); DATA→PROG on STOP with write protect low; DATA→IDLE on STOP with write protect high, or on abort; PROG→IDLE when the cycle counter reaches its end. When strobes coincide, the priority is address, then byte, then STOP, then abort.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset `busy_o` and `arr_we_o` are 0 and `ptr_o` is 0.
- R2: An address strobe while not busy loads `ptr_o` with `addr_i` and clears the valid mask, so no entry from an earlier transaction is committed later.
- R3: A data byte accepted in a transaction is stored at entry `ptr_o[PAGE_AW-1:0]`. The low `PAGE_AW` bits of `ptr_o` then increment modulo `2**PAGE_AW`, and bits `ADDR_W-1:PAGE_AW` stay unchanged.
- R4: When more than `2**PAGE_AW` bytes arrive before STOP, the entries are overwritten in arrival order, and the committed value of each entry is the last byte stored there.
- R5: A STOP after at least one data byte, with write protect low, raises `busy_o` from the next clock edge for exactly `WR_CYCLES` cycles.
- R6: During that window only valid entries are written, one per cycle, in ascending entry order. The array address is `{ptr_o[ADDR_W-1:PAGE_AW], entry}`, and `arr_we_o` is never high while `busy_o` is low.
- R7: A STOP or abort that follows only an address strobe, with no data, starts no write cycle and issues no array write. `ptr_o` keeps the loaded address.
- R8: An abort after data bytes discards them: no busy window and no array write follow, and `ptr_o` keeps its advanced value.
- R9: With write protect high at STOP, bytes are still buffered and the pointer still advances, but no busy window and no array write follow.
- R10: While `busy_o` is high, address strobes, bytes, STOP and abort are ignored: `ptr_o` does not change and no later commit contains those bytes.
- R11: After a commit, `ptr_o` equals the address of the last byte received plus one, wrapped within its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect, high blocks programming |
| addr_set_i | input | 1 | Word address received, starts a write transaction |
| addr_i | input | ADDR_W | Word address |
| byte_vld_i | input | 1 | Data byte received |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP condition seen |
| abort_i | input | 1 | Repeated START seen, write transaction abandoned |
| busy_o | output | 1 | Programming cycle in progress |
| ptr_o | output | ADDR_W | Shared address pointer |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
The bench builds the block with `ADDR_W=10`, `PAGE_AW=4`, `DATA_W=8` and `WR_CYCLES=24`. This keeps the real page geometry, so wrap-around at entry 15 and overruns of 18 bytes are exercised exactly as in use. The short cycle count keeps many full busy windows within the run, and each window is measured cycle by cycle. Because 24 is only a little larger than the 16-cycle scan, strobes sent during busy fall inside the scan itself.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_PROG = 2'd3
    } pwb_state_e;

endpackage

// File: rtl/pwb_addr_ptr.sv
// Shared address pointer: full load, or an increment confined to the page offset.
module pwb_addr_ptr #(
    parameter int ADDR_W  = 10,
    parameter int PAGE_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - PAGE_AW;

    logic [HI_W-1:0]    page_q;
    logic [PAGE_AW-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:PAGE_AW];
            off_q  <= load_addr[PAGE_AW-1:0];
        end else if (step) begin
            off_q  <= off_q + 1'b1;
        end
    end

    assign ptr = {page_q, off_q};
endmodule

// File: rtl/pwb_page_buf.sv
// Page staging storage with a per-entry valid flag.
module pwb_page_buf #(
    parameter int PAGE_AW = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid
);
    localparam int DEPTH = 1 << PAGE_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
                vld_q[e] <= 1'b0;
            end else if (clr) begin
                vld_q[e] <= 1'b0;
            end else if (wr_en && (wr_idx == PAGE_AW'(e))) begin
                mem_q[e] <= wr_data;
                vld_q[e] <= 1'b1;
            end
        end
    end

    assign rd_data  = mem_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/pwb_prog_timer.sv
// Programming cycle counter; the first DEPTH counts double as the scan index.
module pwb_prog_timer #(
    parameter int WR_CYCLES = 1250000,
    parameter int PAGE_AW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    output logic               last,
    output logic               scan_vld,
    output logic [PAGE_AW-1:0] scan_idx
);
    localparam int DEPTH  = 1 << PAGE_AW;
    localparam int CYC    = (WR_CYCLES < DEPTH) ? DEPTH : WR_CYCLES;
    localparam int CNT_W  = $clog2(CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last     = (cnt_q == CNT_W'(CYC - 1));
    assign scan_vld = run && (cnt_q < CNT_W'(DEPTH));
    assign scan_idx = cnt_q[PAGE_AW-1:0];
endmodule

// File: rtl/pwb_page_commit.sv
module pwb_page_commit
    import pwb_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_AW   = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              addr_set_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              stop_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o
);
    pwb_state_e state_q, state_d;

    logic               ptr_load, ptr_step;
    logic               buf_clr, buf_wr;
    logic               tmr_start, tmr_last, scan_vld;
    logic [PAGE_AW-1:0] scan_idx;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: address > byte > STOP > abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_set_i) state_d = ST_ADDR;
            ST_ADDR: begin
                if (addr_set_i)              state_d = ST_ADDR;
                else if (byte_vld_i)         state_d = ST_DATA;
                else if (stop_i || abort_i)  state_d = ST_IDLE;
            end
            ST_DATA: begin
                if (addr_set_i)      state_d = ST_ADDR;
                else if (byte_vld_i) state_d = ST_DATA;
                else if (stop_i)     state_d = wp_i ? ST_IDLE : ST_PROG;
                else if (abort_i)    state_d = ST_IDLE;
            end
            ST_PROG: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        ptr_load  = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        busy_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ptr_load = addr_set_i;
            ST_ADDR: begin
                ptr_load = addr_set_i;
                buf_wr   = byte_vld_i && !addr_set_i;
            end
            ST_DATA: begin
                ptr_load  = addr_set_i;
                buf_wr    = byte_vld_i && !addr_set_i;
                tmr_start = stop_i && !addr_set_i && !byte_vld_i && !wp_i;
            end
            ST_PROG: busy_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
        buf_clr  = ptr_load;
        ptr_step = buf_wr;
    end

    pwb_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_addr (addr_i),
        .step      (ptr_step),
        .ptr       (ptr_o)
    );

    pwb_page_buf #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (ptr_o[PAGE_AW-1:0]),
        .wr_data  (byte_i),
        .rd_idx   (scan_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    pwb_prog_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_AW(PAGE_AW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .run      (state_q == ST_PROG),
        .last     (tmr_last),
        .scan_vld (scan_vld),
        .scan_idx (scan_idx)
    );

    assign arr_we_o   = scan_vld && rd_valid && !wp_i;
    assign arr_addr_o = {ptr_o[ADDR_W-1:PAGE_AW], scan_idx};
    assign arr_data_o = rd_data;
endmodule

// File: rtl/pwb_page_commit_chk.sv
module pwb_page_commit_chk #(
    parameter int ADDR_W  = 10,
    parameter int PAGE_AW = 4,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_i,
    input logic              addr_set_i,
    input logic              byte_vld_i,
    input logic              stop_i,
    input logic              abort_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] ptr_o,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic [DATA_W-1:0] arr_data_o
);
    p_we_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o);

    p_we_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> (arr_addr_o[ADDR_W-1:PAGE_AW] == ptr_o[ADDR_W-1:PAGE_AW]));

    p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    p_abort_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !busy_o) |=> !busy_o);

    p_wp_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && wp_i && !busy_o) |=> !busy_o);

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !addr_set_i && !busy_o)
        |=> (ptr_o[ADDR_W-1:PAGE_AW] == $past(ptr_o[ADDR_W-1:PAGE_AW])));

    p_ptr_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (ptr_o == $past(ptr_o)));
endmodule

bind pwb_page_commit pwb_page_commit_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_AW(PAGE_AW),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_i       (wp_i),
    .addr_set_i (addr_set_i),
    .byte_vld_i (byte_vld_i),
    .stop_i     (stop_i),
    .abort_i    (abort_i),
    .busy_o     (busy_o),
    .ptr_o      (ptr_o),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (arr_addr_o),
    .arr_data_o (arr_data_o)
);

// File: tb/pwb_page_commit_tb.sv
module pwb_page_commit_tb;
    localparam int ADDR_W = 10;
    localparam int PAGE_AW = 4;
    localparam int DATA_W = 8;
    localparam int WRC = 24;
    localparam int DEPTH = 1 << PAGE_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_i = 1'b0;
    logic addr_set_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic byte_vld_i = 1'b0;
    logic [DATA_W-1:0] byte_i = '0;
    logic stop_i = 1'b0;
    logic abort_i = 1'b0;
    logic busy_o, arr_we_o;
    logic [ADDR_W-1:0] ptr_o, arr_addr_o;
    logic [DATA_W-1:0] arr_data_o;

    always #4 clk = ~clk;

    pwb_page_commit #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .DATA_W(DATA_W),
                      .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .addr_set_i(addr_set_i),
        .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .stop_i(stop_i), .abort_i(abort_i), .busy_o(busy_o), .ptr_o(ptr_o),
        .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [ADDR_W+DATA_W-1:0] exp_q [$];

    // Bench model of the pending transaction, built from the requirements
    logic [ADDR_W-1:0] m_ptr = '0;
    logic [DATA_W-1:0] m_buf [DEPTH];
    logic [DEPTH-1:0]  m_vld = '0;
    bit m_open = 1'b0;
    bit m_data = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every array write is popped from the scoreboard and compared
    always @(negedge clk) begin
        if (rst_n && arr_we_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected array write", int'({arr_addr_o, arr_data_o}), 0);
            end else begin
                logic [ADDR_W+DATA_W-1:0] e;
                e = exp_q.pop_front();
                chk({arr_addr_o, arr_data_o} == e, "R6/R4 array write",
                    int'({arr_addr_o, arr_data_o}), int'(e));
            end
        end
    end

    task automatic t_addr(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        if (!busy_o) begin
            m_ptr = a; m_vld = '0; m_open = 1'b1; m_data = 1'b0;
        end
        addr_set_i = 1'b1; addr_i = a;
        @(negedge clk);
        addr_set_i = 1'b0;
    endtask

    task automatic t_byte(input logic [DATA_W-1:0] d);
        @(negedge clk);
        if (!busy_o && m_open) begin
            m_buf[m_ptr[PAGE_AW-1:0]] = d;
            m_vld[m_ptr[PAGE_AW-1:0]] = 1'b1;
            m_ptr[PAGE_AW-1:0] = m_ptr[PAGE_AW-1:0] + 1'b1;
            m_data = 1'b1;
        end
        byte_vld_i = 1'b1; byte_i = d;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic t_stop();
        @(negedge clk);
        if (!busy_o) begin
            if (m_data && !wp_i)
                for (int i = 0; i < DEPTH; i++)
                    if (m_vld[i])
                        exp_q.push_back({m_ptr[ADDR_W-1:PAGE_AW], PAGE_AW'(i), m_buf[i]});
            m_open = 1'b0; m_data = 1'b0;
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic t_abort();
        @(negedge clk);
        if (!busy_o) begin
            m_open = 1'b0; m_data = 1'b0;
        end
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
    endtask

    // Counts busy cycles from the current negedge on, optionally checks length
    task automatic wait_busy(input bit check_len, input string req);
        int n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
        if (check_len) chk(n == WRC, req, n, WRC);
        chk(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic quiet(input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!busy_o, req, busy_o, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !arr_we_o, "R1 reset outputs", {busy_o, arr_we_o}, 0);
        chk(ptr_o == 0, "R1 reset pointer", ptr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R11: single-byte write
        t_addr(10'h123);
        chk(ptr_o == 10'h123, "R2 address load", ptr_o, 10'h123);
        t_byte(8'hA5);
        chk(ptr_o == 10'h124, "R3 pointer step", ptr_o, 10'h124);
        t_stop();
        wait_busy(1'b1, "R5 busy length single byte");
        chk(ptr_o == 10'h124, "R11 pointer after commit", ptr_o, 10'h124);

        // R3: wrap inside the page
        t_addr(10'h2FE);
        t_byte(8'h11); t_byte(8'h22); t_byte(8'h33);
        chk(ptr_o == 10'h2F1, "R3 wrap keeps page", ptr_o, 10'h2F1);
        t_stop();
        wait_busy(1'b1, "R5 busy length wrap");

        // R4: 18 bytes overrun a 16-entry page
        t_addr(10'h040);
        for (int i = 0; i < 18; i++) t_byte(8'(8'h40 + i));
        t_stop();
        wait_busy(1'b1, "R4 busy length overrun");
        chk(ptr_o == 10'h042, "R11 pointer after overrun", ptr_o, 10'h042);

        // R7: STOP and abort with no data
        t_addr(10'h0B7);
        t_stop();
        quiet("R7 stop without data");
        chk(ptr_o == 10'h0B7, "R7 pointer kept", ptr_o, 10'h0B7);
        t_addr(10'h0C0);
        t_abort();
        quiet("R7 abort without data");

        // R8: abort after data
        t_addr(10'h300);
        t_byte(8'h5A); t_byte(8'h6B);
        t_abort();
        quiet("R8 abort discards");
        chk(ptr_o == 10'h302, "R8 pointer kept", ptr_o, 10'h302);
        t_stop();
        quiet("R8 stop after abort");

        // R9: write protect
        wp_i = 1'b1;
        t_addr(10'h010);
        t_byte(8'h01); t_byte(8'h02); t_byte(8'h03);
        chk(ptr_o == 10'h013, "R9 pointer advances", ptr_o, 10'h013);
        t_stop();
        quiet("R9 no busy under protect");
        wp_i = 1'b0;

        // R10: strobes during busy are ignored
        t_addr(10'h1E0);
        t_byte(8'h99);
        t_stop();
        chk(busy_o, "R5 busy raised", busy_o, 1);
        t_addr(10'h3A0);
        t_byte(8'h77);
        t_stop();
        chk(ptr_o == 10'h1E1, "R10 pointer held in busy", ptr_o, 10'h1E1);
        wait_busy(1'b0, "R10");
        quiet("R10 no commit from busy strobes");

        // R2: mask cleared, a fully valid page does not leak into a new one-byte write
        t_addr(10'h045);
        t_byte(8'hC3);
        t_stop();
        wait_busy(1'b1, "R2 busy length after mask clear");
        chk(ptr_o == 10'h046, "R11 pointer final", ptr_o, 10'h046);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule